// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets a processor talk to Ethernet PHY management registers over the two-wire MDC/MDIO bus. Software programs a clock divider and a preamble switch once. It then writes one 32-bit command word that already holds the whole management frame: start, opcode, PHY address, register address, turnaround and data. The block sends that word bit for bit. It can prefix the word with a preamble of ones.

In a read frame the master releases MDIO from the turnaround onward. It captures the sixteen bits the PHY drives and places them in the low half of the command register. When the last bit has gone by, a sticky completion flag is set. Software clears the flag by writing one to it. A command written while a frame is in flight is dropped.

Top module: `mdio_host`

## Requirements
- R1: Three word-addressed registers. Offset 0 is control: bits 6:0 hold the divider and bit 7 enables the preamble. Offset 1 is the command word. Offset 2 is status, with the completion flag in bit 0. All three read as zero after reset, and offset 3 reads as zero.
- R2: Writing offset 1 while idle starts one frame. The 32 command bits go out on `mdio_o` most significant bit first, one bit per MDC period, and exactly 32 MDC rising edges occur when the preamble is off.
- R3: With control bit 7 set, 32 bits of one precede the command bits, for 64 MDC periods in total.
- R4: MDC has a period of 2×(divider+1) system clocks, and a divider of 0 acts as 1. MDC stays low while no frame is in progress.
- R5: `mdio_o` and `mdio_oe` change only together with a falling MDC edge or at frame start, so they are stable across every MDC rising edge.
- R6: A command whose bits 29:28 are 10 is a read. During a read, `mdio_oe` is low from frame bit 14 (the first turnaround bit, command bit 17) to the end. During a write frame `mdio_oe` stays high for all bits, and it is low when idle.
- R7: At the end of a read, the 16 bits sampled on the MDC rising edges of frame bits 16..31 (first sample most significant) replace command bits 15:0. Bits 31:16 keep their value.
- R8: The status flag is set when a frame ends. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R9: If completion and a clearing write fall in the same cycle, the flag ends up set.
- R10: A write to offset 1 while a frame is in progress is ignored. The frame on the wire and the command readback are unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdio_i | input | 1 | MDIO level seen from the bus |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |

## Verification
The end of a frame sets the completion flag, and a software write clears it. Both can land in the same clock cycle. The bench counts MDC rising edges to find the last bit of a frame. It then places a write-one-to-clear on the exact clock edge where completion registers, and expects the flag to read back as set. A follow-up clearing write must then drop the flag. A further collision comes from a command write issued mid-frame: it must neither disturb the serialized bits nor change the readback.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the MDIO management master.
// Assumes word-addressed registers on a 2-bit offset bus.
package mdio_pkg;
    localparam int CTRL_OFS   = 0;
    localparam int CMD_OFS    = 1;
    localparam int STATUS_OFS = 2;

    localparam int DIV_W      = 7;
    localparam int WORD_W     = 32;
    localparam int RD_W       = 16;
    localparam int PRE_LEN    = 32;

    // Opcode value (command bits 29:28) that marks a read frame
    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
    } mdio_ctrl_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator: divides clk by 2*(div+1) while run is high, treating
// div==0 as 1. It flags the cycle before each MDC rising and falling edge.
// Assumes run stays high until the cycle in which the last fall tick occurs.
module mdio_mdc_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] term;
    logic             at_term;

    // Effective half-period terminal count
    always_comb term = (div == '0) ? DIV_W'(1) : div;

    assign at_term   = run && (cnt == term);
    assign rise_tick = at_term && !mdc;
    assign fall_tick = at_term && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: on start, sends an optional preamble of ones, then the
// command word MSB first. Bits advance on MDC fall ticks. For reads it
// releases the bus from the turnaround and shifts in data on rise ticks.
// Assumes start is only asserted while idle.
module mdio_frame_engine #(
    parameter int WORD_W  = 32,
    parameter int RD_W    = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] cmd,
    input  logic              pre_en,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              done_rd,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [RD_W-1:0]   rd_data
);
    import mdio_pkg::*;

    localparam int POS_W    = $clog2(WORD_W);
    localparam int PRE_W    = $clog2(PRE_LEN);
    localparam int TA_POS   = WORD_W - RD_W - 2;
    localparam int DATA_POS = WORD_W - RD_W;

    logic              in_pre;
    logic [PRE_W-1:0]  pre_cnt;
    logic [POS_W-1:0]  pos;
    logic [WORD_W-1:0] sh;
    logic              is_rd;
    logic [RD_W-1:0]   rd_sh;
    logic              last_bit;
    logic              released;

    assign last_bit = !in_pre && (pos == POS_W'(WORD_W - 1));
    assign released = is_rd && !in_pre && (pos >= POS_W'(TA_POS));
    assign done     = busy && fall_tick && last_bit;
    assign done_rd  = done && is_rd;
    assign mdio_o   = busy ? (in_pre ? 1'b1 : sh[WORD_W-1]) : 1'b1;
    assign mdio_oe  = busy && !released;
    assign rd_data  = rd_sh;

    // Frame sequencing: load on start, advance on MDC fall ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            in_pre  <= 1'b0;
            pre_cnt <= '0;
            pos     <= '0;
            sh      <= '0;
            is_rd   <= 1'b0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            in_pre  <= pre_en;
            pre_cnt <= '0;
            pos     <= '0;
            sh      <= cmd;
            is_rd   <= (cmd[WORD_W-3:WORD_W-4] == OP_READ);
        end else if (busy && fall_tick) begin
            if (in_pre) begin
                if (pre_cnt == PRE_W'(PRE_LEN - 1))
                    in_pre <= 1'b0;
                pre_cnt <= pre_cnt + 1'b1;
            end else if (last_bit) begin
                busy <= 1'b0;
            end else begin
                pos <= pos + 1'b1;
                sh  <= {sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Read data capture on MDC rise ticks during the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sh <= '0;
        end else if (busy && rise_tick && is_rd && !in_pre &&
                     (pos >= POS_W'(DATA_POS))) begin
            rd_sh <= {rd_sh[RD_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_csr.sv
// Register file: control (divider, preamble), command word with read-data
// merge, and a sticky write-one-to-clear completion flag where set wins.
// Assumes one write strobe per cycle; reads are combinational.
module mdio_csr #(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 32,
    parameter int DIV_W  = 7,
    parameter int RD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_rd,
    input  logic [RD_W-1:0]   rd_data,
    output logic              start,
    output logic [DIV_W-1:0]  div,
    output logic              pre_en,
    output logic [WORD_W-1:0] cmd_q,
    output logic              status_flag
);
    import mdio_pkg::*;

    mdio_ctrl_t ctrl_q;
    logic       wr_ctrl, wr_cmd, wr_stat;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(CMD_OFS));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(STATUS_OFS));
    assign start   = wr_cmd && !busy;
    assign div     = ctrl_q.div;
    assign pre_en  = ctrl_q.pre_en;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= mdio_ctrl_t'(bus_wdata[DIV_W:0]);
    end

    // Command register: loaded at launch, low half replaced by read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (start)
            cmd_q <= bus_wdata;
        else if (done_rd)
            cmd_q[RD_W-1:0] <= rd_data;
    end

    // Completion flag: set on frame end, W1C, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_flag <= 1'b0;
        else if (done)
            status_flag <= 1'b1;
        else if (wr_stat && bus_wdata[0])
            status_flag <= 1'b0;
    end

    // Read-back multiplexer
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            CTRL_OFS:   bus_rdata[DIV_W:0] = ctrl_q;
            CMD_OFS:    bus_rdata = cmd_q;
            STATUS_OFS: bus_rdata[0] = status_flag;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_host.sv
// Top of the MDIO management master: ties the register file, the MDC
// generator and the frame engine together. Assumes a single clock domain
// and an external pull-up on MDIO.
module mdio_host #(
    parameter int ADDR_W = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    import mdio_pkg::*;

    logic             busy, done, done_rd, start;
    logic             rise_tick, fall_tick;
    logic [RD_W-1:0]  rd_data;
    logic [DIV_W-1:0] div;
    logic             pre_en;
    logic [WORD_W-1:0] cmd_q;
    logic             status_flag;

    mdio_csr #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DIV_W(DIV_W), .RD_W(RD_W)
    ) u_csr (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .done_rd(done_rd), .rd_data(rd_data),
        .start(start), .div(div), .pre_en(pre_en),
        .cmd_q(cmd_q), .status_flag(status_flag)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_engine #(
        .WORD_W(WORD_W), .RD_W(RD_W), .PRE_LEN(PRE_LEN)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(bus_wdata),
        .pre_en(pre_en), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .mdio_i(mdio_i), .busy(busy), .done(done), .done_rd(done_rd),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
    );
endmodule

// File: rtl/mdio_host_chk.sv
// Assertion checker for mdio_host, attached through bind. Observes the
// top-level pins and the internal busy/done/flag/command state.
module mdio_host_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done,
    input logic        status_flag,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] cmd_q
);
    a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r8_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> status_flag);

    a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && bus_wr && bus_addr == 2'd1) |=> $stable(cmd_q));
endmodule

bind mdio_host mdio_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .status_flag(status_flag), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cmd_q(cmd_q)
);

// File: tb/mdio_host_test.sv
// Directed bench for mdio_host: one task per scenario, PHY responder model.
module mdio_host_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_CMD = 2'd1, A_STAT = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int checks = 0, failures = 0;
    bit finished = 0;

    bit     obs_o  [0:1023];
    bit     obs_oe [0:1023];
    longint rise_t [0:1023];
    int     rise_cnt = 0;
    int     base = 0;
    int     resp_off = 0;
    bit     resp_on = 0;
    logic [15:0] resp_data = '0;
    int     r5_viol = 0;
    logic   mdc_p = 1'b0, mdo_p = 1'b1, oe_p = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_host uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // Record master pin values at each MDC rising edge
    always @(posedge mdc) begin
        if (rise_cnt < 1024) begin
            obs_o[rise_cnt]  = mdio_o;
            obs_oe[rise_cnt] = mdio_oe;
            rise_t[rise_cnt] = $time / CLK_PERIOD;
        end
        rise_cnt = rise_cnt + 1;
    end

    // PHY responder: drive read data after MDC falls
    always @(negedge mdc) begin
        if (resp_on) begin
            int idx;
            idx = rise_cnt - base - resp_off;
            if (idx >= 0 && idx < 16) mdio_i <= resp_data[15-idx];
            else                      mdio_i <= 1'b1;
        end
    end

    // R5 monitor: pins must not change in the cycle MDC rises
    always @(negedge clk) begin
        if (mdc && !mdc_p && (mdio_o != mdo_p || mdio_oe != oe_p))
            r5_viol = r5_viol + 1;
        mdc_p = mdc; mdo_p = mdio_o; oe_p = mdio_oe;
    end

    task automatic chk(input string req, input bit ok,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] frame_at(input int s);
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[31-i] = obs_o[s+i];
        return w;
    endfunction

    task automatic launch(input logic [31:0] cmd, input bit pre,
                          input logic [15:0] resp);
        bus_write(A_STAT, 32'h1);
        base = rise_cnt;
        resp_off = (pre ? 32 : 0) + 16;
        resp_data = resp;
        resp_on = 1;
        bus_write(A_CMD, cmd);
    endtask

    task automatic wait_flag(input string req);
        logic [31:0] s;
        int n = 0;
        s = '0;
        while (s[0] !== 1'b1 && n < 3000) begin
            bus_read(A_STAT, s);
            n++;
        end
        chk(req, s[0] === 1'b1, s, 1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(A_CTRL, d); chk("R1 ctrl reset", d == 0, d, 0);
        bus_read(A_CMD, d);  chk("R1 cmd reset", d == 0, d, 0);
        bus_read(A_STAT, d); chk("R1 status reset", d == 0, d, 0);
        bus_read(2'd3, d);   chk("R1 unused offset", d == 0, d, 0);
        chk("R4 mdc idle low", mdc == 1'b0, mdc, 0);
        chk("R6 idle oe low", mdio_oe == 1'b0, mdio_oe, 0);
    endtask

    task automatic t_write_frame;
        logic [31:0] cmd, d;
        bit oe_all = 1;
        cmd = {4'h5, 5'd3, 5'd9, 2'b10, 16'hBEEF};
        bus_write(A_CTRL, 32'h01);
        launch(cmd, 0, 16'h0);
        wait_flag("R8 flag set after write frame");
        chk("R2 rise count", rise_cnt - base == 32, rise_cnt - base, 32);
        chk("R2 frame bits", frame_at(base) == cmd, frame_at(base), cmd);
        for (int i = 0; i < 32; i++) if (!obs_oe[base+i]) oe_all = 0;
        chk("R6 write oe high", oe_all, oe_all, 1);
        chk("R4 mdc low after frame", mdc == 1'b0, mdc, 0);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, d); chk("R8 write 0 keeps flag", d[0] == 1, d, 1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, d); chk("R8 write 1 clears", d[0] == 0, d, 0);
    endtask

    task automatic t_preamble;
        logic [31:0] cmd;
        bit ones = 1;
        cmd = {4'h5, 5'd17, 5'd30, 2'b10, 16'h0F0F};
        bus_write(A_CTRL, 32'h81);
        launch(cmd, 1, 16'h0);
        wait_flag("R8 flag after preamble frame");
        chk("R3 rise count", rise_cnt - base == 64, rise_cnt - base, 64);
        for (int i = 0; i < 32; i++) if (!obs_o[base+i]) ones = 0;
        chk("R3 preamble ones", ones, ones, 1);
        chk("R3 frame after preamble", frame_at(base + 32) == cmd,
            frame_at(base + 32), cmd);
    endtask

    task automatic t_mdc_period(input logic [6:0] dv, input int per);
        longint p1, p2;
        bus_write(A_CTRL, {25'd0, dv});
        launch({4'h5, 5'd1, 5'd1, 2'b10, 16'h1234}, 0, 16'h0);
        wait_flag("R8 flag after period frame");
        p1 = rise_t[base+1] - rise_t[base];
        p2 = rise_t[base+31] - rise_t[base+30];
        chk("R4 mdc period start", p1 == per, p1, per);
        chk("R4 mdc period end", p2 == per, p2, per);
    endtask

    task automatic t_read;
        logic [31:0] cmd, d;
        bit oe_ok = 1;
        cmd = {4'h6, 5'd5, 5'd2, 2'b10, 16'h0000};
        bus_write(A_CTRL, 32'h81);
        launch(cmd, 1, 16'hA53C);
        wait_flag("R8 flag after read");
        for (int i = 0; i < 32; i++)
            if (obs_oe[base+32+i] != (i < 14)) oe_ok = 0;
        chk("R6 read oe release pattern", oe_ok, oe_ok, 1);
        bus_read(A_CMD, d);
        chk("R7 read data merged", d == {cmd[31:16], 16'hA53C}, d,
            {cmd[31:16], 16'hA53C});
        bus_write(A_CTRL, 32'h02);
        launch({4'h6, 5'd31, 5'd0, 2'b10, 16'hFFFF}, 0, 16'h8001);
        wait_flag("R8 flag after second read");
        bus_read(A_CMD, d);
        chk("R7 read no preamble", d == {4'h6, 5'd31, 5'd0, 2'b10, 16'h8001},
            d, {4'h6, 5'd31, 5'd0, 2'b10, 16'h8001});
    endtask

    task automatic t_busy_ignore;
        logic [31:0] a, b, d;
        a = {4'h5, 5'd7, 5'd12, 2'b10, 16'hC0DE};
        b = {4'h6, 5'd1, 5'd1, 2'b10, 16'h0000};
        bus_write(A_CTRL, 32'h01);
        launch(a, 0, 16'h0);
        while (rise_cnt - base < 5) @(negedge clk);
        bus_write(A_CMD, b);
        bus_read(A_CMD, d);
        chk("R10 readback during busy", d == a, d, a);
        wait_flag("R8 flag after ignore test");
        repeat (100) @(negedge clk);
        chk("R10 no second frame", rise_cnt - base == 32, rise_cnt - base, 32);
        chk("R10 frame unchanged", frame_at(base) == a, frame_at(base), a);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        bus_write(A_CTRL, 32'h01);
        launch({4'h5, 5'd2, 5'd3, 2'b10, 16'h5555}, 0, 16'h0);
        while (rise_cnt - base < 32) @(negedge clk);
        // half period is 2 clocks: completion registers on the next edge pair
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 d = bus_rdata;
        chk("R9 set wins over clear", d[0] == 1, d, 1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, d);
        chk("R9 later clear works", d[0] == 0, d, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_frame();
        t_preamble();
        t_mdc_period(7'd3, 8);
        t_mdc_period(7'd0, 4);
        t_read();
        t_busy_ignore();
        t_collision();
        chk("R5 pins stable at MDC rise", r5_viol == 0, r5_viol, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule